// File: doc/BRIEF.md
# Configurable Chip-Select-Gated Register Buffer

This block registers a parallel address/command word on every rising clock edge and drives registered copies of it to its outputs. Two static configuration inputs choose the shape of the buffer. In the wide shape, up to 25 data positions each drive one output. In the split shape, only 14 positions are used and each registered bit drives two outputs, an A copy and a B copy. The split shape has two channel maps, and the maps differ in which positions carry ordinary data.

A pair of chip-select inputs can freeze the ordinary data outputs so that they do not toggle while the addressed device is deselected. The registered chip-select, on-die-termination and clock-enable channels are never frozen. They have their own input ports and their own registered outputs. An asynchronous active-low reset clears every output at once and overrides every other control. The block sits between a memory controller's command bus and a bank of memory devices on a module.

Data position p (1 to 25) is carried on bit p-1 of `din`, `q_data_a` and `q_data_b`.

Top module: `cfg_regbuf`

## Requirements
- R1: While `rst_n` is LOW, every output is LOW. The outputs clear as soon as `rst_n` falls, with no clock edge, whatever the other inputs are doing.
- R2: With `cfg_split` LOW (wide mode), `q_data_a` bit p-1 shows `din` bit p-1 as registered at the last loading edge for positions 2, 3, 5, 6 and 8 to 25. Positions 1, 4 and 7 are LOW.
- R3: In wide mode, `q_data_b`, `q_cs_b`, `q_odt_b` and `q_cke_b` are LOW.
- R4: With `cfg_split` HIGH and `cfg_alt_map` LOW (map A), the active positions are 2, 3, 5, 6 and 8 to 14. All other bits of `q_data_a` are LOW, and `q_data_b` equals bits 13:0 of `q_data_a`.
- R5: With `cfg_split` HIGH and `cfg_alt_map` HIGH (map B), the active positions are 1 to 6, 8 to 10, 12 and 13. All other bits of `q_data_a` are LOW, and `q_data_b` equals bits 13:0 of `q_data_a`.
- R6: When `cs_dev` and `cs_rank` are both HIGH at a rising edge, the registered data word keeps its previous value.
- R7: When either chip-select is LOW at a rising edge, the data word loads `din`. With `cs_rank` tied LOW, `cs_dev` acts as a plain registered bit.
- R8: `q_cs_a` takes the value of `cs_dev` at every rising edge, whatever `cs_rank` is.
- R9: `q_odt_a` and `q_cke_a` take `odt_in` and `cke_in` at every rising edge, whatever the chip-selects are. In split mode, each B copy equals its A copy.
- R10: A change on `cfg_split` or `cfg_alt_map` does not affect the outputs until the next rising edge.
- R11: A change on any data or control input between edges leaves every output unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is captured on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_split | input | 1 | LOW: wide one-to-one; HIGH: split one-to-two |
| cfg_alt_map | input | 1 | Split mode channel map: LOW map A, HIGH map B |
| cs_dev | input | 1 | Device chip-select; registered to `q_cs_*` |
| cs_rank | input | 1 | Rank chip-select; gating is active when both chip-selects are HIGH |
| odt_in | input | 1 | Termination control input, never gated |
| cke_in | input | 1 | Clock-enable control input, never gated |
| din | input | 25 | Data positions 1..25 on bits 0..24 |
| q_data_a | output | 25 | Registered data, primary copy |
| q_data_b | output | 14 | Registered data, secondary copy (split mode) |
| q_cs_a | output | 1 | Registered chip-select, primary copy |
| q_cs_b | output | 1 | Registered chip-select, secondary copy |
| q_odt_a | output | 1 | Registered termination control, primary copy |
| q_odt_b | output | 1 | Registered termination control, secondary copy |
| q_cke_a | output | 1 | Registered clock-enable, primary copy |
| q_cke_b | output | 1 | Registered clock-enable, secondary copy |

## Verification
The bench builds the block with its default widths: 25 data positions and a 14-position split copy. These defaults bring into reach positions 15 to 25, which only wide mode drives, and the position-11 and position-14 holes that only map B leaves. Each configuration runs under all four chip-select combinations with alternating and all-ones data patterns. This exposes any position that leaks between maps or any control channel that wrongly freezes. Directed steps then assert reset mid-cycle and change configuration and data between edges.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;

    localparam int WIDE_W   = 25;
    localparam int NARROW_W = 14;

    // data positions (1-based) with special meaning in some maps
    localparam int POS_CKE_A = 1;
    localparam int POS_ODT_A = 4;
    localparam int POS_GAP   = 7;
    localparam int POS_ODT_B = 11;
    localparam int POS_CKE_B = 14;

    typedef enum logic [1:0] {
        MODE_WIDE    = 2'd0,
        MODE_SPLIT_A = 2'd1,
        MODE_SPLIT_B = 2'd2
    } rb_mode_e;

    typedef struct packed {
        logic cs;
        logic odt;
        logic cke;
    } rb_ctrl_t;

    function automatic rb_mode_e decode_mode(input logic split, input logic alt);
        if (!split)
            return MODE_WIDE;
        return alt ? MODE_SPLIT_B : MODE_SPLIT_A;
    endfunction

    function automatic logic is_split(input rb_mode_e m);
        return (m != MODE_WIDE);
    endfunction

    // one bit per data position: 1 = ordinary data lane in this map
    function automatic logic [WIDE_W-1:0] lane_mask(input rb_mode_e m);
        logic [WIDE_W-1:0] mk;
        logic act;
        mk = '0;
        for (int p = 1; p <= WIDE_W; p++) begin
            case (m)
                MODE_WIDE:
                    act = (p != POS_CKE_A) && (p != POS_ODT_A) && (p != POS_GAP);
                MODE_SPLIT_A:
                    act = (p <= NARROW_W) && (p != POS_CKE_A) &&
                          (p != POS_ODT_A) && (p != POS_GAP);
                default:
                    act = (p <= NARROW_W) && (p != POS_GAP) &&
                          (p != POS_ODT_B) && (p != POS_CKE_B);
            endcase
            mk[p-1] = act;
        end
        return mk;
    endfunction

endpackage

// File: rtl/rb_mode_reg.sv
module rb_mode_reg
    import rbuf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_split,
    input  logic     cfg_alt_map,
    output rb_mode_e mode_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= MODE_WIDE;
        else
            mode_q <= decode_mode(cfg_split, cfg_alt_map);
    end

endmodule

// File: rtl/rb_data_bank.sv
module rb_data_bank #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (load)
                bit_q <= d[i];
        end
        assign q[i] = bit_q;
    end

endmodule

// File: rtl/rb_ctrl_bank.sv
module rb_ctrl_bank
    import rbuf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  rb_ctrl_t d,
    output rb_ctrl_t q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

endmodule

// File: rtl/rb_fanout.sv
module rb_fanout
    import rbuf_pkg::*;
#(
    parameter int DATA_W = WIDE_W,
    parameter int FAN_W  = NARROW_W
) (
    input  rb_mode_e          mode,
    input  logic [DATA_W-1:0] data_q,
    input  rb_ctrl_t          ctrl_q,
    output logic [DATA_W-1:0] out_a,
    output logic [FAN_W-1:0]  out_b,
    output rb_ctrl_t          ctrl_a,
    output rb_ctrl_t          ctrl_b
);

    logic [WIDE_W-1:0] mask_w;
    logic              split;

    assign mask_w = lane_mask(mode);
    assign split  = is_split(mode);

    always_comb begin
        out_a  = data_q & mask_w;
        out_b  = split ? out_a[FAN_W-1:0] : '0;
        ctrl_a = ctrl_q;
        ctrl_b = split ? ctrl_q : '0;
    end

endmodule

// File: rtl/cfg_regbuf.sv
module cfg_regbuf
    import rbuf_pkg::*;
#(
    parameter int DATA_W = WIDE_W,
    parameter int FAN_W  = NARROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_split,
    input  logic              cfg_alt_map,
    input  logic              cs_dev,
    input  logic              cs_rank,
    input  logic              odt_in,
    input  logic              cke_in,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q_data_a,
    output logic [FAN_W-1:0]  q_data_b,
    output logic              q_cs_a,
    output logic              q_cs_b,
    output logic              q_odt_a,
    output logic              q_odt_b,
    output logic              q_cke_a,
    output logic              q_cke_b
);

    rb_mode_e          mode_q;
    logic [DATA_W-1:0] data_q;
    rb_ctrl_t          ctrl_d, ctrl_q, ctrl_a, ctrl_b;
    logic              load_en;

    // data lanes freeze only while both selects are high
    assign load_en = !(cs_dev && cs_rank);
    assign ctrl_d  = '{cs: cs_dev, odt: odt_in, cke: cke_in};

    rb_mode_reg u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_split   (cfg_split),
        .cfg_alt_map (cfg_alt_map),
        .mode_q      (mode_q)
    );

    rb_data_bank #(.W(DATA_W)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_en),
        .d     (din),
        .q     (data_q)
    );

    rb_ctrl_bank u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctrl_d),
        .q     (ctrl_q)
    );

    rb_fanout #(.DATA_W(DATA_W), .FAN_W(FAN_W)) u_fan (
        .mode   (mode_q),
        .data_q (data_q),
        .ctrl_q (ctrl_q),
        .out_a  (q_data_a),
        .out_b  (q_data_b),
        .ctrl_a (ctrl_a),
        .ctrl_b (ctrl_b)
    );

    assign q_cs_a  = ctrl_a.cs;
    assign q_odt_a = ctrl_a.odt;
    assign q_cke_a = ctrl_a.cke;
    assign q_cs_b  = ctrl_b.cs;
    assign q_odt_b = ctrl_b.odt;
    assign q_cke_b = ctrl_b.cke;

endmodule

// File: rtl/cfg_regbuf_checker.sv
module cfg_regbuf_checker #(
    parameter int DATA_W = 25,
    parameter int FAN_W  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_split,
    input logic              cfg_alt_map,
    input logic              cs_dev,
    input logic              cs_rank,
    input logic              odt_in,
    input logic              cke_in,
    input logic [DATA_W-1:0] q_data_a,
    input logic [FAN_W-1:0]  q_data_b,
    input logic              q_cs_a,
    input logic              q_cs_b,
    input logic              q_odt_a,
    input logic              q_odt_b,
    input logic              q_cke_a,
    input logic              q_cke_b
);

    // R1: sampled mid-cycle, outputs are all low while reset is held
    always @(negedge clk) begin
        if (rst_n == 1'b0) begin
            p_reset_clear_r1: assert (q_data_a == '0 && q_data_b == '0 &&
                                      !q_cs_a && !q_cs_b && !q_odt_a &&
                                      !q_odt_b && !q_cke_a && !q_cke_b);
        end
    end

    p_wide_b_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_split |=> (q_data_b == '0 && !q_cs_b && !q_odt_b && !q_cke_b));

    p_split_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_split |=> (q_data_b == q_data_a[FAN_W-1:0] && q_cs_b == q_cs_a &&
                       q_odt_b == q_odt_a && q_cke_b == q_cke_a));

    p_gate_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_dev && cs_rank && $stable(cfg_split) && $stable(cfg_alt_map))
        |=> $stable(q_data_a));

    p_cs_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q_cs_a == $past(cs_dev)));

    p_ctrl_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q_odt_a == $past(odt_in) && q_cke_a == $past(cke_in)));

endmodule

bind cfg_regbuf cfg_regbuf_checker #(.DATA_W(DATA_W), .FAN_W(FAN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_split   (cfg_split),
    .cfg_alt_map (cfg_alt_map),
    .cs_dev      (cs_dev),
    .cs_rank     (cs_rank),
    .odt_in      (odt_in),
    .cke_in      (cke_in),
    .q_data_a    (q_data_a),
    .q_data_b    (q_data_b),
    .q_cs_a      (q_cs_a),
    .q_cs_b      (q_cs_b),
    .q_odt_a     (q_odt_a),
    .q_odt_b     (q_odt_b),
    .q_cke_a     (q_cke_a),
    .q_cke_b     (q_cke_b)
);

// File: tb/cfg_regbuf_test.sv
module cfg_regbuf_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 25;
    localparam int FW = 14;

    typedef struct packed {
        logic          split;
        logic          alt;
        logic          dcs;
        logic          csr;
        logic          odt;
        logic          cke;
        logic [DW-1:0] din;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 25'h1FFFFFF},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 25'h0000000},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 25'h0AAAAAA},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 25'h1555555},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 25'h1FFFFFF},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 25'h0000000},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 25'h1FFFFFF},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 25'h0000000},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 25'h0123456},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 25'h1ABCDEF},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 25'h1FFFFFF},
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 25'h0000000},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 25'h0F0F0F0},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 25'h1F0F0F0},
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 25'h1234567}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_split = 1'b0;
    logic          cfg_alt_map = 1'b0;
    logic          cs_dev = 1'b0;
    logic          cs_rank = 1'b0;
    logic          odt_in = 1'b0;
    logic          cke_in = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] q_data_a;
    logic [FW-1:0] q_data_b;
    logic          q_cs_a, q_cs_b, q_odt_a, q_odt_b, q_cke_a, q_cke_b;

    int  n_checks = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    // reference state: 0 wide, 1 map A, 2 map B
    int            m_mode = 0;
    logic [DW-1:0] m_data = '0;
    logic          m_cs = 1'b0, m_odt = 1'b0, m_cke = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_regbuf uut (
        .clk (clk), .rst_n (rst_n), .cfg_split (cfg_split),
        .cfg_alt_map (cfg_alt_map), .cs_dev (cs_dev), .cs_rank (cs_rank),
        .odt_in (odt_in), .cke_in (cke_in), .din (din),
        .q_data_a (q_data_a), .q_data_b (q_data_b),
        .q_cs_a (q_cs_a), .q_cs_b (q_cs_b), .q_odt_a (q_odt_a),
        .q_odt_b (q_odt_b), .q_cke_a (q_cke_a), .q_cke_b (q_cke_b)
    );

    // active data positions per map, from R2, R4, R5
    function automatic logic pos_active(int mode, int p);
        if (p == 7) return 1'b0;
        if (mode == 0) return !(p == 1 || p == 4);
        if (p > 14) return 1'b0;
        if (mode == 1) return !(p == 1 || p == 4);
        return !(p == 11 || p == 14);
    endfunction

    task automatic model_reset();
        m_mode = 0; m_data = '0; m_cs = 0; m_odt = 0; m_cke = 0;
    endtask

    task automatic model_edge();
        m_mode = !cfg_split ? 0 : (cfg_alt_map ? 2 : 1);
        if (!(cs_dev && cs_rank)) m_data = din;
        m_cs = cs_dev; m_odt = odt_in; m_cke = cke_in;
    endtask

    task automatic check(string tag);
        logic [DW-1:0] ea;
        logic [FW-1:0] eb;
        logic [5:0]    ec, ac;
        for (int p = 1; p <= DW; p++)
            ea[p-1] = m_data[p-1] & pos_active(m_mode, p);
        eb = (m_mode != 0) ? ea[FW-1:0] : '0;
        ec = (m_mode != 0) ? {m_cs, m_cs, m_odt, m_odt, m_cke, m_cke}
                           : {m_cs, 1'b0, m_odt, 1'b0, m_cke, 1'b0};
        ac = {q_cs_a, q_cs_b, q_odt_a, q_odt_b, q_cke_a, q_cke_b};
        n_checks++;
        if (q_data_a !== ea || q_data_b !== eb || ac !== ec) begin
            n_bad++;
            $display("FAIL %s actual a=%h b=%h c=%b expected a=%h b=%h c=%b",
                     tag, q_data_a, q_data_b, ac, ea, eb, ec);
        end
    endtask

    function automatic string vec_tag(vec_t v);
        if (v.dcs && v.csr) return "R6 R8 R9";
        if (!v.split) return "R2 R3 R7";
        if (!v.alt) return "R4 R7 R9";
        return "R5 R7 R9";
    endfunction

    // called at a falling edge: drive, capture, compare at next falling edge
    task automatic apply(vec_t v, string tag);
        cfg_split = v.split; cfg_alt_map = v.alt; cs_dev = v.dcs;
        cs_rank = v.csr; odt_in = v.odt; cke_in = v.cke; din = v.din;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        // reset state
        model_reset();
        @(negedge clk);
        check("R1");
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++)
            apply(VEC[i], vec_tag(VEC[i]));

        // R11: inputs change between edges; outputs must wait for the edge
        apply('{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 25'h1555555}, "R2");
        #2;
        din = 25'h0AAAAAA; cs_dev = 1'b1; odt_in = 1'b0; cke_in = 1'b0;
        #1;
        check("R11");
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("R11");

        // R10: configuration change mid-cycle is held off until the edge
        apply('{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 25'h1FFFFFF}, "R2");
        #2;
        cfg_split = 1'b1; cfg_alt_map = 1'b1;
        #1;
        check("R10");
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("R10");

        // R7: cs_rank tied low, cs_dev behaves as a registered bit
        apply('{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 25'h0ABCDE1}, "R7");
        apply('{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 25'h0000F0F}, "R7");

        // R1: reset asserted mid-cycle clears at once and overrides selects
        apply('{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 25'h1FFFFFF}, "R2");
        #2;
        rst_n = 1'b0;
        #1;
        model_reset();
        check("R1");
        cs_dev = 1'b0; cs_rank = 1'b0; din = 25'h1FFFFFF;
        @(posedge clk);
        @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        apply('{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 25'h1FFFFFF}, "R4");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
        $finish;
    end

endmodule